// File: doc/BRIEF.md
# Registered Signed Multiply-Add Cell

This cell computes `(A x B) + C` on two's complement operands as one stage of a transposed-form FIR filter. Each cell holds one filter weight. Partial sums pass from one cell's output into the next cell's addend input. Two 12-bit operands are captured into their own enabled registers. Their signed 24-bit product is registered every cycle. The product is sign-extended to 26 bits and added to a 26-bit addend held in a third enabled register.

The 26-bit sum is registered on every edge. A feedthrough control picks what the cell presents: the combinational sum, or the registered copy that is one cycle older. The registered copy is used to insert a zero-weight tap, or to run two interleaved sample streams through the same filter. An output-disable control releases the result bus to high impedance. A plain data view and a drive flag stay readable for checking.

The cell takes no back-pressure and has no valid/ready handshake. A data word is taken at a clock edge only when its capture enable is high. The result is presented every cycle. The consumer must take it in the cycle it appears.

Top module: `mac_cell`

## Requirements
- R1: When `rst_n` is low at a rising edge, every internal register (both operands, addend, product and sum) is cleared to zero. After reset, `s_data` reads 0 in both output modes.
- R2: `a_reg` loads `a_in` on a rising edge only when `a_en` is 1, and `b_reg` loads `b_in` only when `b_en` is 1. Otherwise each holds its value.
- R3: On every rising edge the product register loads the signed 24-bit product of `a_reg` and `b_reg`, all values two's complement. The product register has no enable.
- R4: `c_reg` loads the 26-bit two's complement `c_in` on a rising edge only when `c_en` is 1. Otherwise it holds.
- R5: The sum is `c_reg` plus the product register sign-extended to 26 bits. It wraps modulo 2^26, with no saturation and no overflow flag.
- R6: On every rising edge the sum register loads the current sum, with no enable.
- R7: With `feed_thru` = 1, `s_data` is the current combinational sum. With `feed_thru` = 0, `s_data` is the sum register, which is the sum from one cycle earlier. An operand captured at edge k therefore appears at edge k+1 in feedthrough mode and at edge k+2 in registered mode.
- R8: With `out_hiz` = 1, `s_bus` is high impedance and `s_drive` is 0, while `s_data` still carries the result. With `out_hiz` = 0, `s_drive` is 1 and `s_bus` equals `s_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 12 | Multiplicand, two's complement |
| a_en | input | 1 | Capture enable for `a_in` |
| b_in | input | 12 | Multiplier (coefficient), two's complement |
| b_en | input | 1 | Capture enable for `b_in` |
| c_in | input | 26 | Addend / cascaded partial sum, two's complement |
| c_en | input | 1 | Capture enable for `c_in` |
| feed_thru | input | 1 | 1: present combinational sum; 0: present sum register |
| out_hiz | input | 1 | 1: release `s_bus` to high impedance |
| s_bus | output | 26 | Tri-state result bus |
| s_data | output | 26 | Result value, always driven |
| s_drive | output | 1 | 1 when `s_bus` is actively driven |

## Verification
Two events can land on the same rising edge: a newly enabled addend captured into `c_reg`, and a new product loaded into the product register. The next sum must combine both new values, not one new value with one stale value. The bench provokes this by raising `c_en` in the cycle that follows an operand capture. In that cycle it also flips `feed_thru`, so the presented value and its source change at once. Each cycle is judged against a register-level reference model built from the requirements, in both output modes and with the bus released.

// File: rtl/mac_cell_pkg.sv
package mac_cell_pkg;
  localparam int unsigned OPA_W_DEF = 12;
  localparam int unsigned OPB_W_DEF = 12;
  localparam int unsigned ACC_W_DEF = 26;

  typedef enum logic {
    OUT_REGISTERED = 1'b0,
    OUT_FEEDTHRU   = 1'b1
  } out_sel_e;
endpackage

// File: rtl/mac_capture_reg.sv
module mac_capture_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  // R2, R4: register holds while its enable is low
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> $stable(q));

  // R2, R4: register takes the presented word when enabled
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en)) |-> (q == $past(d)));
endmodule

// File: rtl/mac_product_stage.sv
module mac_product_stage #(
  parameter int unsigned A_W = 12,
  parameter int unsigned B_W = 12,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_q,
  input  logic [B_W-1:0] b_q,
  output logic [P_W-1:0] p_q
);
  logic signed [P_W-1:0] prod;

  always_comb prod = $signed(a_q) * $signed(b_q);

  always_ff @(posedge clk) begin
    if (!rst_n) p_q <= '0;
    else        p_q <= prod;
  end

  // R3: product register follows the operand registers one edge later
  p_prod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($signed(p_q) ==
      ($signed({{B_W{$past(a_q[A_W-1])}}, $past(a_q)}) *
       $signed({{A_W{$past(b_q[B_W-1])}}, $past(b_q)}))));
endmodule

// File: rtl/mac_sum_stage.sv
module mac_sum_stage
  import mac_cell_pkg::*;
#(
  parameter int unsigned P_W = 24,
  parameter int unsigned C_W = 26,
  localparam int unsigned EXT = (C_W > P_W) ? (C_W - P_W) : 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] p_q,
  input  logic [C_W-1:0] c_q,
  input  out_sel_e       sel,
  output logic [C_W-1:0] out
);
  logic [C_W-1:0] p_ext;
  logic [C_W-1:0] sum;
  logic [C_W-1:0] s_q;

  generate
    if (EXT > 0) begin : g_widen
      assign p_ext = {{EXT{p_q[P_W-1]}}, p_q};
    end else begin : g_trim
      assign p_ext = p_q[C_W-1:0];
    end
  endgenerate

  always_comb sum = c_q + p_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= sum;
  end

  always_comb out = (sel == OUT_FEEDTHRU) ? sum : s_q;

  // R6: sum register holds the previous cycle's sum
  p_sreg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (s_q == $past(sum)));
endmodule

// File: rtl/mac_cell.sv
module mac_cell
  import mac_cell_pkg::*;
#(
  parameter int unsigned A_W = OPA_W_DEF,
  parameter int unsigned B_W = OPB_W_DEF,
  parameter int unsigned C_W = ACC_W_DEF,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_in,
  input  logic           a_en,
  input  logic [B_W-1:0] b_in,
  input  logic           b_en,
  input  logic [C_W-1:0] c_in,
  input  logic           c_en,
  input  logic           feed_thru,
  input  logic           out_hiz,
  output logic [C_W-1:0] s_bus,
  output logic [C_W-1:0] s_data,
  output logic           s_drive
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic [C_W-1:0] c_q;
  logic [P_W-1:0] p_q;
  out_sel_e       sel;

  mac_capture_reg #(.W(A_W)) u_a_reg (
    .clk(clk), .rst_n(rst_n), .en(a_en), .d(a_in), .q(a_q));
  mac_capture_reg #(.W(B_W)) u_b_reg (
    .clk(clk), .rst_n(rst_n), .en(b_en), .d(b_in), .q(b_q));
  mac_capture_reg #(.W(C_W)) u_c_reg (
    .clk(clk), .rst_n(rst_n), .en(c_en), .d(c_in), .q(c_q));

  mac_product_stage #(.A_W(A_W), .B_W(B_W)) u_prod (
    .clk(clk), .rst_n(rst_n), .a_q(a_q), .b_q(b_q), .p_q(p_q));

  always_comb sel = feed_thru ? OUT_FEEDTHRU : OUT_REGISTERED;

  mac_sum_stage #(.P_W(P_W), .C_W(C_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .p_q(p_q), .c_q(c_q), .sel(sel), .out(s_data));

  always_comb s_drive = !out_hiz;
  assign s_bus = out_hiz ? {C_W{1'bz}} : s_data;

  // R8: bus is driven whenever the output is enabled
  p_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hiz |-> s_drive);
endmodule

// File: tb/mac_cell_bench.sv
module mac_cell_bench;
  localparam int CW = 26;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] a_in = '0, b_in = '0;
  logic [25:0] c_in = '0;
  logic a_en = 0, b_en = 0, c_en = 0, feed_thru = 1, out_hiz = 0;
  wire  [25:0] s_bus;
  logic [25:0] s_data;
  logic        s_drive;
  int total = 0, bad = 0;

  // reference state
  logic [11:0] ma = '0, mb = '0;
  logic [23:0] mp = '0;
  logic [25:0] mc = '0, ms = '0;

  always #4 clk = ~clk;

  mac_cell u_mac_cell (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_en(a_en), .b_in(b_in), .b_en(b_en),
    .c_in(c_in), .c_en(c_en), .feed_thru(feed_thru), .out_hiz(out_hiz),
    .s_bus(s_bus), .s_data(s_data), .s_drive(s_drive));

  function automatic logic [25:0] msum();
    return mc + {{2{mp[23]}}, mp};
  endfunction

  function automatic logic [25:0] mexp();
    return feed_thru ? msum() : ms;
  endfunction

  task automatic chk(input string tag, input logic [25:0] got, input logic [25:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [11:0] a, input logic [11:0] b, input logic [25:0] c,
                      input logic ea, input logic eb, input logic ec,
                      input logic ft, input logic hz);
    logic [23:0] np;
    logic [25:0] ns;
    @(negedge clk);
    a_in = a; b_in = b; c_in = c; a_en = ea; b_en = eb; c_en = ec;
    feed_thru = ft; out_hiz = hz;
    @(posedge clk);
    if (!rst_n) begin
      ma = '0; mb = '0; mc = '0; mp = '0; ms = '0;
    end else begin
      np = 24'($signed(ma) * $signed(mb));
      ns = msum();
      mp = np; ms = ns;
      if (ea) ma = a;
      if (eb) mb = b;
      if (ec) mc = c;
    end
    #2;
  endtask

  task automatic t_reset();
    rst_n = 0;
    step(12'h7FF, 12'h7FF, 26'h155, 1, 1, 1, 1, 0);
    step(12'h7FF, 12'h7FF, 26'h155, 1, 1, 1, 0, 0);
    chk("R1 registered mode zero", s_data, 26'd0);
    feed_thru = 1; #1;
    chk("R1 feedthrough zero", s_data, 26'd0);
    rst_n = 1;
  endtask

  task automatic t_products();
    logic [11:0] av[6] = '{12'd3, 12'h800, 12'h800, 12'h7FF, 12'hFFF, 12'd0};
    logic [11:0] bv[6] = '{12'd5, 12'h800, 12'h7FF, 12'h7FF, 12'd1, 12'h123};
    for (int i = 0; i < 6; i++) begin
      step(av[i], bv[i], 26'd100, 1, 1, 1, 1, 0);
      step(12'd0, 12'd0, 26'd100, 0, 0, 1, 1, 0);
      chk("R3 R5 signed product plus addend", s_data, mexp());
    end
  endtask

  task automatic t_enables();
    step(12'd10, 12'd20, 26'd7, 1, 1, 1, 1, 0);
    step(12'd99, 12'd77, 26'd500, 0, 0, 0, 1, 0);
    step(12'd55, 12'd33, 26'd900, 0, 0, 0, 1, 0);
    chk("R2 R4 disabled captures keep old value", s_data, 26'd207);
    chk("R2 R4 model agrees", s_data, mexp());
    step(12'd2, 12'd99, 26'd1, 1, 0, 1, 1, 0);
    step(12'd0, 12'd0, 26'd1, 0, 0, 0, 1, 0);
    chk("R2 only A updated", s_data, 26'd41);
  endtask

  task automatic t_wrap();
    step(12'h7FF, 12'h7FF, 26'h1FFFFFF, 1, 1, 1, 1, 0);
    step(12'd0, 12'd0, 26'h1FFFFFF, 0, 0, 0, 1, 0);
    chk("R5 positive wrap", s_data, 26'h1FFFFFF + 26'd4190209);
    step(12'h800, 12'h7FF, 26'h2000000, 1, 1, 1, 1, 0);
    step(12'd0, 12'd0, 26'h2000000, 0, 0, 0, 1, 0);
    chk("R5 negative wrap", s_data, mexp());
  endtask

  task automatic t_registered();
    step(12'd4, 12'd6, 26'd1000, 1, 1, 1, 0, 0);
    step(12'd0, 12'd0, 26'd0, 0, 0, 0, 0, 0);
    chk("R7 registered lags", s_data, mexp());
    step(12'd0, 12'd0, 26'd0, 0, 0, 0, 0, 0);
    chk("R6 R7 registered sum after two edges", s_data, 26'd1024);
  endtask

  task automatic t_hiz();
    step(12'd9, 12'd9, 26'd0, 1, 1, 1, 1, 1);
    step(12'd0, 12'd0, 26'd0, 0, 0, 0, 1, 1);
    chk("R8 drive flag low", {25'd0, s_drive}, 26'd0);
    chk("R8 data still valid", s_data, 26'd81);
    total++;
    if (s_bus === s_data && s_data != 0) begin
      bad++;
      $display("FAIL R8 bus not released: got %h expected z", s_bus);
    end
    step(12'd0, 12'd0, 26'd0, 0, 0, 0, 1, 0);
    chk("R8 drive flag high", {25'd0, s_drive}, 26'd1);
    chk("R8 bus equals data", s_bus, s_data);
  endtask

  task automatic t_collide();
    step(12'hFFE, 12'd300, 26'd5, 1, 1, 0, 0, 0);
    step(12'd0, 12'd0, 26'd12345, 0, 0, 1, 1, 0);
    chk("R4 R5 new addend and new product same edge", s_data, mexp());
    step(12'd0, 12'd0, 26'd0, 0, 0, 0, 0, 0);
    chk("R6 R7 mode flip shows registered", s_data, mexp());
    chk("R7 registered collided sum", s_data, 26'd12345 - 26'd600);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_products();
    t_enables();
    t_wrap();
    t_registered();
    t_hiz();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule